// File: doc/BRIEF.md
# Dual-Port Contention Arbiter

This block sits beside a shared two-port memory and decides which port keeps a word when both ports reach for it at once. Each port (A and B) presents a chip enable, a write strobe and a word address. When both enables are active and the two addresses are equal, the port that got there first keeps access and the other port receives an active-low busy flag. The write enable that the block passes on to the array is masked for the losing port. It is a clocked model of an asynchronous arbiter: "getting there first" means an earlier clock edge.

A mode strap selects master or slave operation. As master, the block runs its own arbitration and drives both busy flags. As slave, which is used when several devices are cascaded to build a wider word, the block drives its busy outputs high. It then gates each port's write with a busy flag that arrives from the master, so that a slave never writes a word that the master has taken from that port.

The arbiter FSM has three states. `ARB_FREE` means no contention. In `ARB_A_HOLDS`, port A owns the word and B is busy. In `ARB_B_HOLDS`, port B owns the word and A is busy. The transitions are:
- **claim**: from `ARB_FREE` to a hold state. It is taken when a match exists in master mode.
- **release**: from a hold state back to `ARB_FREE`. It is taken when the match ends or the strap goes to slave.
- **keep**: a hold state stays as it is while the match persists.

A port counts as "arriving" on a cycle when its enable has just risen or its address has changed since the previous cycle. When both ports arrive on the same cycle, a tie bit picks the winner and then flips, so the winner of a tie alternates.

Top module: `dp_contention_arb`

## Requirements
- R1: After reset both busy outputs are high, the arbiter holds no winner, and the tie bit selects port A for the first tie.
- R2: A match exists only when both enables are high and the addresses are equal. Without a match, no busy output goes low.
- R3: A match caused by port A changing its address makes A busy from the next cycle while B keeps access, provided B was already enabled at that address. The same holds with the ports swapped.
- R4: A match caused by a port's enable rising while the addresses already agree makes that port busy from the next cycle.
- R5: One cycle after the match ends, both busy outputs are high again. The match ends when the addresses differ or either enable falls.
- R6: When both ports arrive on the same cycle, only one becomes busy. The first tie after reset keeps A (B is busy), and each later tie picks the port that did not win the previous tie.
- R7: The two busy outputs are never low at the same time.
- R8: With the strap low (slave mode), both busy outputs stay high. Each port's write enable out equals its enable AND its write strobe AND its busy input, where busy input high means not busy.
- R9: With the strap high (master mode), a port's write enable out equals its enable AND its write strobe, and is forced low while that port's busy output is low.
- R10: While a match persists, the winner does not change, even if the losing port toggles its write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| is_master | input | 1 | mode strap: 1 master, 0 slave |
| ce_a | input | 1 | port A enable, active high |
| we_a | input | 1 | port A write strobe, active high |
| addr_a | input | ADDR_W | port A word address |
| ce_b | input | 1 | port B enable, active high |
| we_b | input | 1 | port B write strobe, active high |
| addr_b | input | ADDR_W | port B word address |
| busy_in_a_n | input | 1 | slave mode: busy for port A from the master, active low |
| busy_in_b_n | input | 1 | slave mode: busy for port B from the master, active low |
| busy_a_n | output | 1 | busy to port A, active low |
| busy_b_n | output | 1 | busy to port B, active low |
| wr_en_a | output | 1 | gated write enable to the array for port A |
| wr_en_b | output | 1 | gated write enable to the array for port B |

## Verification
The directed patterns are chosen so that each one tells a different arbitration rule apart:
- Different addresses with both ports enabled separate a true match from mere activity.
- An address moving onto a standing port separates address-triggered claims from enable-triggered ones.
- Dropping each port's enable in turn shows that release works in both directions.
- Two simultaneous arrivals, repeated, show both the first tie winner and the alternation.
- A slave-mode phase drives the busy inputs to show that writes are gated from outside.

A long pseudo-random phase over four addresses then mixes all of these patterns against a behavioural model on every cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic [1:0] {
        ARB_FREE    = 2'd0,
        ARB_A_HOLDS = 2'd1,
        ARB_B_HOLDS = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dpa_arrival.sv
// Flags a port as freshly arriving: enable just rose or address moved.
module dpa_arrival #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              prev_ce;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ce   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_ce   <= ce;
            prev_addr <= addr;
        end
    end

    always_comb begin
        fresh = ce && (!prev_ce || (addr != prev_addr));
    end
endmodule

// File: rtl/dpa_fsm.sv
module dpa_fsm
    import dpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic       match,
    input  logic       fresh_a,
    input  logic       fresh_b,
    output arb_state_t state
);
    arb_state_t state_nx;
    logic       tie_b;
    logic       tie_b_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_FREE;
            tie_b <= 1'b0;
        end else begin
            state <= state_nx;
            tie_b <= tie_b_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tie_b_nx = tie_b;
        unique case (state)
            ARB_FREE: begin
                if (master && match) begin
                    if (fresh_a && !fresh_b) begin
                        state_nx = ARB_B_HOLDS;
                    end else if (fresh_b && !fresh_a) begin
                        state_nx = ARB_A_HOLDS;
                    end else begin
                        state_nx = tie_b ? ARB_B_HOLDS : ARB_A_HOLDS;
                        tie_b_nx = !tie_b;
                    end
                end
            end
            ARB_A_HOLDS, ARB_B_HOLDS: begin
                if (!master || !match) state_nx = ARB_FREE;
            end
            default: state_nx = ARB_FREE;
        endcase
    end
endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
    input  logic master,
    input  logic lose,
    input  logic ce,
    input  logic we,
    input  logic busy_in_n,
    output logic busy_n,
    output logic wr_en
);
    always_comb begin
        busy_n = !(master && lose);
        if (master) wr_en = ce && we && !lose;
        else        wr_en = ce && we && busy_in_n;
    end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              ce_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              ce_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              busy_in_a_n,
    input  logic              busy_in_b_n,
    output logic              busy_a_n,
    output logic              busy_b_n,
    output logic              wr_en_a,
    output logic              wr_en_b
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]       ce_v, we_v, bin_v, fresh_v, lose_v, busy_v, wr_v;
    logic [ADDR_W-1:0]      addr_v [NPORT];
    logic                   match;
    arb_state_t             state;

    assign ce_v   = {ce_b, ce_a};
    assign we_v   = {we_b, we_a};
    assign bin_v  = {busy_in_b_n, busy_in_a_n};
    assign addr_v[0] = addr_a;
    assign addr_v[1] = addr_b;
    assign match  = ce_a && ce_b && (addr_a == addr_b);
    assign lose_v = {state == ARB_A_HOLDS, state == ARB_B_HOLDS};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dpa_arrival #(.ADDR_W(ADDR_W)) u_arr (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce_v[g]),
            .addr  (addr_v[g]),
            .fresh (fresh_v[g])
        );
        dpa_port_gate u_gate (
            .master    (is_master),
            .lose      (lose_v[g]),
            .ce        (ce_v[g]),
            .we        (we_v[g]),
            .busy_in_n (bin_v[g]),
            .busy_n    (busy_v[g]),
            .wr_en     (wr_v[g])
        );
    end

    dpa_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (is_master),
        .match   (match),
        .fresh_a (fresh_v[0]),
        .fresh_b (fresh_v[1]),
        .state   (state)
    );

    assign busy_a_n = busy_v[0];
    assign busy_b_n = busy_v[1];
    assign wr_en_a  = wr_v[0];
    assign wr_en_b  = wr_v[1];
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic              ce_a,
    input logic              we_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic              ce_b,
    input logic              we_b,
    input logic [ADDR_W-1:0] addr_b,
    input logic              busy_in_a_n,
    input logic              busy_in_b_n,
    input logic              busy_a_n,
    input logic              busy_b_n,
    input logic              wr_en_a,
    input logic              wr_en_b
);
    logic hit;
    assign hit = ce_a && ce_b && (addr_a == addr_b);

    // R7
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_a_n && !busy_b_n));

    // R5
    release_after_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (busy_a_n && busy_b_n));

    // R2
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_a_n || !busy_b_n) |-> $past(hit && is_master));

    // R8
    slave_busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (busy_a_n && busy_b_n));

    // R9
    loser_write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && (!busy_a_n || !busy_b_n)) |->
            !((!busy_a_n && wr_en_a) || (!busy_b_n && wr_en_b)));

    // R8
    slave_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (wr_en_a == (ce_a && we_a && busy_in_a_n)) &&
                       (wr_en_b == (ce_b && we_b && busy_in_b_n)));
endmodule

bind dp_contention_arb dpa_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .ce_a(ce_a), .we_a(we_a), .addr_a(addr_a),
    .ce_b(ce_b), .we_b(we_b), .addr_b(addr_b),
    .busy_in_a_n(busy_in_a_n), .busy_in_b_n(busy_in_b_n),
    .busy_a_n(busy_a_n), .busy_b_n(busy_b_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b)
);

// File: tb/tb_dp_contention_arb.sv
`timescale 1ns/1ps
module tb_dp_contention_arb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master = 1'b1;
    logic          ce_a = 0, we_a = 0, ce_b = 0, we_b = 0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic          busy_in_a_n = 1'b1, busy_in_b_n = 1'b1;
    logic          busy_a_n, busy_b_n, wr_en_a, wr_en_b;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dp_contention_arb #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .ce_a(ce_a), .we_a(we_a), .addr_a(addr_a),
        .ce_b(ce_b), .we_b(we_b), .addr_b(addr_b),
        .busy_in_a_n(busy_in_a_n), .busy_in_b_n(busy_in_b_n),
        .busy_a_n(busy_a_n), .busy_b_n(busy_b_n),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b)
    );

    // behavioural reference: owner 0 none, 1 port A keeps, 2 port B keeps
    int         owner = 0;
    bit         next_tie_b = 0;
    bit         was_ce_a = 0, was_ce_b = 0;
    int         was_addr_a = 0, was_addr_b = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            owner = 0; next_tie_b = 0;
            was_ce_a = 0; was_ce_b = 0; was_addr_a = 0; was_addr_b = 0;
        end else begin
            bit same, arr_a, arr_b;
            same  = ce_a && ce_b && (addr_a == addr_b);
            arr_a = ce_a && (!was_ce_a || int'(addr_a) != was_addr_a);
            arr_b = ce_b && (!was_ce_b || int'(addr_b) != was_addr_b);
            if (owner != 0) begin
                if (!is_master || !same) owner = 0;
            end else if (is_master && same) begin
                if (arr_a && !arr_b)      owner = 2;
                else if (arr_b && !arr_a) owner = 1;
                else begin
                    owner = next_tie_b ? 2 : 1;
                    next_tie_b = !next_tie_b;
                end
            end
            was_ce_a = ce_a; was_ce_b = ce_b;
            was_addr_a = int'(addr_a); was_addr_b = int'(addr_b);
        end
    end

    task automatic chk1(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        logic ea, eb, wa, wb;
        ea = !(is_master && owner == 2);
        eb = !(is_master && owner == 1);
        wa = ce_a && we_a && (is_master ? owner != 2 : busy_in_a_n);
        wb = ce_b && we_b && (is_master ? owner != 1 : busy_in_b_n);
        chk1(req, "busy_a_n", busy_a_n, ea);
        chk1(req, "busy_b_n", busy_b_n, eb);
        chk1(req, "wr_en_a", wr_en_a, wa);
        chk1(req, "wr_en_b", wr_en_b, wb);
    endtask

    // compare the state left by the last edge, then apply new inputs
    task automatic drive(string req, logic ca, logic wea, int aa, logic cb, logic web, int ab);
        @(negedge clk);
        compare(req);
        ce_a = ca; we_a = wea; addr_a = AW'(aa);
        ce_b = cb; we_b = web; addr_b = AW'(ab);
        #1;
        compare(req);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk1("R1", "busy_a_n", busy_a_n, 1'b1);
        chk1("R1", "busy_b_n", busy_b_n, 1'b1);
        rst_n = 1'b1;
        // R2 both enabled, different words
        drive("R2", 1, 1, 5, 1, 1, 7);
        drive("R2", 1, 1, 5, 1, 1, 7);
        // R3 B moves onto A's word: A keeps, B busy and masked (R9)
        drive("R3", 1, 1, 5, 1, 1, 5);
        drive("R9", 1, 1, 5, 1, 1, 5);
        chk1("R3", "busy_b_n", busy_b_n, 1'b0);
        // R10 loser toggles strobe, winner unchanged
        drive("R10", 1, 1, 5, 1, 0, 5);
        drive("R10", 1, 0, 5, 1, 1, 5);
        // R5 mismatch releases
        drive("R5", 1, 1, 5, 1, 1, 9);
        drive("R5", 0, 0, 5, 1, 1, 5);
        // R4 A enable rises on B's word
        drive("R4", 1, 1, 5, 1, 1, 5);
        drive("R4", 1, 1, 5, 1, 1, 5);
        chk1("R4", "busy_a_n", busy_a_n, 1'b0);
        // R5 winner drops enable
        drive("R5", 1, 1, 5, 0, 0, 5);
        drive("R5", 0, 0, 5, 0, 0, 5);
        // R6 simultaneous arrival: first tie A keeps
        drive("R6", 1, 1, 3, 1, 1, 3);
        drive("R6", 1, 1, 3, 1, 1, 3);
        chk1("R6", "busy_b_n", busy_b_n, 1'b0);
        drive("R6", 0, 0, 3, 0, 0, 3);
        drive("R6", 1, 1, 8, 1, 1, 8);
        drive("R6", 1, 1, 8, 1, 1, 8);
        chk1("R6", "busy_a_n", busy_a_n, 1'b0);
        drive("R6", 0, 0, 0, 0, 0, 0);
        // R8 slave mode with external busy
        is_master = 1'b0;
        drive("R8", 1, 1, 2, 1, 1, 2);
        busy_in_a_n = 1'b0; #1; compare("R8");
        drive("R8", 1, 1, 2, 1, 1, 2);
        busy_in_a_n = 1'b1; busy_in_b_n = 1'b0; #1; compare("R8");
        drive("R8", 1, 1, 4, 1, 1, 6);
        busy_in_b_n = 1'b1;
        is_master = 1'b1;
        drive("R2", 0, 0, 0, 0, 0, 0);
        // R7 mixed random traffic on a small address set
        for (int i = 0; i < 3000; i++) begin
            drive("R7", logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 1)),
                  $urandom_range(0, 3),
                  logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 1)),
                  $urandom_range(0, 3));
            chk1("R7", "not both busy", busy_a_n | busy_b_n, 1'b1);
        end
        @(negedge clk);
        compare("R7");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule